// File: doc/BRIEF.md
# Protected Watchdog Mode Register

This block holds the 8-bit mode byte that configures a watchdog timer. Its run enable, its count-clock select field and its request-priority bit all live in this byte. Software can change the byte only through a guarded write. A guarded write carries a value byte and a check byte, and the value is committed only when the check byte is the exact bitwise inverse of the value. A guarded write whose check fails leaves the byte unchanged. It raises a one-cycle operand-error interrupt and captures the address of the faulting instruction, so the offending code location can be found later. Ordinary store-style writes (move from a register, read-modify-write AND, single-bit set) are accepted on the bus and discarded without any effect. The mode byte is visible at all times on a read port.

The priority bit controls a small arbiter that sits between a non-maskable pin request and a watchdog overflow request. Each request pulse is held pending until it is acknowledged. When both requests are pending, the priority bit decides which one is granted first. The other request stays pending and is granted once the winner has been acknowledged.

Top module: `wdm_ctrl`

## Requirements
- R1: After reset, mode_rd is 0x00, err_irq is 0, err_addr is 0, and neither grant is asserted.
- R2: A write with wr_valid=1, wr_kind=0 (guarded) and wr_check == ~wr_value sets mode_rd to wr_value & 0x96 in the cycle after the strobe.
- R3: A guarded write whose wr_check is not ~wr_value leaves mode_rd unchanged. err_irq is 1 in the following cycle only, and returns to 0 unless another failing write follows.
- R4: On a failing guarded write, err_addr takes the value of fault_addr sampled with the strobe. Passing guarded writes and unguarded writes leave err_addr unchanged.
- R5: Writes with wr_kind 1 (register move), 2 (AND) or 3 (bit set) change neither mode_rd nor err_addr, and they raise no err_irq.
- R6: Bits 6, 5, 3 and 0 of mode_rd always read 0, whatever data was written.
- R7: run equals mode_rd bit 7, prio_wdt equals bit 4, and clk_sel equals bits 2:1.
- R8: With prio_wdt=0 and both requests pending, grant_nmi is asserted and grant_wdt is not.
- R9: With prio_wdt=1 and both requests pending, grant_wdt is asserted and grant_nmi is not.
- R10: A request pulse (nmi_req or wdt_req high for one cycle) stays pending until it is granted and ack is high. The losing request is granted in the cycle after the winner is acknowledged.
- R11: At most one grant is asserted in any cycle, and after every pending request has been acknowledged, no grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 guarded, 1 register move, 2 AND, 3 bit set |
| wr_value | input | 8 | Value byte |
| wr_check | input | 8 | Check byte (must be ~wr_value for guarded) |
| fault_addr | input | AW | Address of the current write instruction |
| mode_rd | output | 8 | Current mode byte |
| run | output | 1 | Watchdog run enable |
| clk_sel | output | 2 | Watchdog count-clock select |
| prio_wdt | output | 1 | 1: watchdog request outranks pin request |
| err_irq | output | 1 | Operand-error interrupt pulse |
| err_addr | output | AW | Captured faulting address |
| nmi_req | input | 1 | Non-maskable pin request pulse |
| wdt_req | input | 1 | Watchdog overflow request pulse |
| ack | input | 1 | Acknowledge of the current grant |
| grant_nmi | output | 1 | Pin request granted |
| grant_wdt | output | 1 | Watchdog request granted |

## Verification
The bench targets check bytes that differ from the true complement in a single bit, because a loose comparison would commit those values instead of raising the error. It also sends value bytes with the fixed-zero bits set, which a design without masking would let leak into the readback. Every unguarded write kind is issued with data that would visibly change the byte, so an unguarded path that is partly honoured shows up as a wrong value or as a stray error pulse. Both requests are raised together under each priority setting, so an inverted priority shows up at once and a loser that is dropped never receives its grant.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    localparam logic [7:0] MODE_MASK = 8'h96;
    localparam int BIT_RUN  = 7;
    localparam int BIT_PRIO = 4;
    localparam int BIT_CS_HI = 2;
    localparam int BIT_CS_LO = 1;

    typedef enum logic [1:0] {
        WK_GUARDED = 2'd0,
        WK_MOVE    = 2'd1,
        WK_AND     = 2'd2,
        WK_SETBIT  = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic pend_nmi;
        logic pend_wdt;
    } arb_state_t;
endpackage

// File: rtl/wdm_write_guard.sv
module wdm_write_guard
    import wdm_pkg::*;
(
    input  logic       wr_valid,
    input  logic [1:0] wr_kind,
    input  logic [7:0] wr_value,
    input  logic [7:0] wr_check,
    output logic       commit,
    output logic       fault,
    output logic [7:0] commit_data
);
    wr_kind_e kind;
    logic     guarded;
    logic     pair_ok;

    always_comb begin
        kind        = wr_kind_e'(wr_kind);
        guarded     = wr_valid && (kind == WK_GUARDED);
        pair_ok     = ((wr_value ^ wr_check) == 8'hFF);
        commit      = guarded && pair_ok;
        fault       = guarded && !pair_ok;
        commit_data = wr_value & MODE_MASK;
    end
endmodule

// File: rtl/wdm_arbiter.sv
module wdm_arbiter
    import wdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prio_wdt,
    input  logic nmi_req,
    input  logic wdt_req,
    input  logic ack,
    output logic grant_nmi,
    output logic grant_wdt
);
    arb_state_t st_d, st_q;

    always_comb begin
        grant_nmi = st_q.pend_nmi && (!st_q.pend_wdt || !prio_wdt);
        grant_wdt = st_q.pend_wdt && (!st_q.pend_nmi || prio_wdt);
        st_d = st_q;
        if (ack && grant_nmi) st_d.pend_nmi = 1'b0;
        if (ack && grant_wdt) st_d.pend_wdt = 1'b0;
        if (nmi_req) st_d.pend_nmi = 1'b1;
        if (wdt_req) st_d.pend_wdt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
    import wdm_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [1:0]    wr_kind,
    input  logic [7:0]    wr_value,
    input  logic [7:0]    wr_check,
    input  logic [AW-1:0] fault_addr,
    output logic [7:0]    mode_rd,
    output logic          run,
    output logic [1:0]    clk_sel,
    output logic          prio_wdt,
    output logic          err_irq,
    output logic [AW-1:0] err_addr,
    input  logic          nmi_req,
    input  logic          wdt_req,
    input  logic          ack,
    output logic          grant_nmi,
    output logic          grant_wdt
);
    typedef struct packed {
        logic [7:0]    mode;
        logic          irq;
        logic [AW-1:0] addr;
    } reg_t;

    reg_t r_d, r_q;
    logic       commit, fault;
    logic [7:0] commit_data;

    wdm_write_guard u_guard (
        .wr_valid    (wr_valid),
        .wr_kind     (wr_kind),
        .wr_value    (wr_value),
        .wr_check    (wr_check),
        .commit      (commit),
        .fault       (fault),
        .commit_data (commit_data)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = fault;
        if (commit) r_d.mode = commit_data;
        if (fault)  r_d.addr = fault_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_rd  = r_q.mode;
    assign run      = r_q.mode[BIT_RUN];
    assign prio_wdt = r_q.mode[BIT_PRIO];
    assign clk_sel  = r_q.mode[BIT_CS_HI:BIT_CS_LO];
    assign err_irq  = r_q.irq;
    assign err_addr = r_q.addr;

    wdm_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prio_wdt  (prio_wdt),
        .nmi_req   (nmi_req),
        .wdt_req   (wdt_req),
        .ack       (ack),
        .grant_nmi (grant_nmi),
        .grant_wdt (grant_wdt)
    );
endmodule

// File: rtl/wdm_ctrl_chk.sv
module wdm_ctrl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic [1:0]    wr_kind,
    input logic [7:0]    wr_value,
    input logic [7:0]    wr_check,
    input logic [AW-1:0] fault_addr,
    input logic [7:0]    mode_rd,
    input logic          prio_wdt,
    input logic          err_irq,
    input logic [AW-1:0] err_addr,
    input logic          grant_nmi,
    input logic          grant_wdt
);
    logic good_wr, bad_wr, other_wr;
    assign good_wr  = wr_valid && wr_kind == 2'd0 && wr_check == ~wr_value;
    assign bad_wr   = wr_valid && wr_kind == 2'd0 && wr_check != ~wr_value;
    assign other_wr = wr_valid && wr_kind != 2'd0;

    a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> mode_rd == ($past(wr_value) & 8'h96));
    a_r3_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> $stable(mode_rd) && err_irq);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !err_irq);
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> err_addr == $past(fault_addr));
    a_r5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(mode_rd) && $stable(err_addr) && !err_irq);
    a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd & 8'h69) == 8'h00);
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_nmi, grant_wdt}));
endmodule

bind wdm_ctrl wdm_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/wdm_ctrl_test.sv
`timescale 1ns/1ps
module wdm_ctrl_test;
    localparam int AW = 20;
    logic clk = 0;
    logic rst_n = 0;
    logic wr_valid = 0;
    logic [1:0] wr_kind = 0;
    logic [7:0] wr_value = 0, wr_check = 0;
    logic [AW-1:0] fault_addr = 0;
    logic [7:0] mode_rd;
    logic run, prio_wdt, err_irq, grant_nmi, grant_wdt;
    logic [1:0] clk_sel;
    logic [AW-1:0] err_addr;
    logic nmi_req = 0, wdt_req = 0, ack = 0;

    int compared = 0, mismatched = 0;
    logic done = 0;
    logic [7:0] exp_mode = 0;
    logic [AW-1:0] exp_addr = 0;

    always #2.5 clk = ~clk;

    wdm_ctrl #(.AW(AW)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pair_ok(input logic [7:0] v, input logic [7:0] c);
        return c == ~v;
    endfunction

    task automatic check_fields(input string tag);
        chk({tag, " mode"}, {24'd0, mode_rd}, {24'd0, exp_mode});
        chk("R6 zero bits", {24'd0, mode_rd & 8'h69}, 32'd0);
        chk("R7 run", {31'd0, run}, {31'd0, exp_mode[7]});
        chk("R7 prio", {31'd0, prio_wdt}, {31'd0, exp_mode[4]});
        chk("R7 clk_sel", {30'd0, clk_sel}, {30'd0, exp_mode[2:1]});
        chk("R4 err_addr", {12'd0, err_addr}, {12'd0, exp_addr});
    endtask

    // one write; sample one ns after the committing edge
    task automatic do_write(input logic [1:0] k, input logic [7:0] v,
                            input logic [7:0] c, input logic [AW-1:0] a, input string tag);
        logic bad;
        @(negedge clk);
        wr_valid = 1; wr_kind = k; wr_value = v; wr_check = c; fault_addr = a;
        bad = (k == 2'd0) && !pair_ok(v, c);
        if (k == 2'd0 && !bad) exp_mode = v & 8'h96;
        if (bad) exp_addr = a;
        @(posedge clk); #1;
        wr_valid = 0;
        chk({tag, " irq"}, {31'd0, err_irq}, {31'd0, bad});
        check_fields(tag);
    endtask

    task automatic arb_case(input logic p, input string tag);
        @(negedge clk);
        nmi_req = 1; wdt_req = 1;
        @(posedge clk); #1;
        nmi_req = 0; wdt_req = 0;
        chk({tag, " winner nmi"}, {31'd0, grant_nmi}, {31'd0, !p});
        chk({tag, " winner wdt"}, {31'd0, grant_wdt}, {31'd0, p});
        @(posedge clk); #1;
        chk("R10 held until ack", {30'd0, grant_nmi, grant_wdt}, {30'd0, !p, p});
        @(negedge clk); ack = 1;
        @(posedge clk); #1; ack = 0;
        chk("R10 loser nmi", {31'd0, grant_nmi}, {31'd0, p});
        chk("R10 loser wdt", {31'd0, grant_wdt}, {31'd0, !p});
        @(negedge clk); ack = 1;
        @(posedge clk); #1; ack = 0;
        chk("R11 idle", {30'd0, grant_nmi, grant_wdt}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mode", {24'd0, mode_rd}, 32'd0);
        chk("R1 reset irq", {31'd0, err_irq}, 32'd0);
        chk("R1 reset addr", {12'd0, err_addr}, 32'd0);
        chk("R1 reset grants", {30'd0, grant_nmi, grant_wdt}, 32'd0);
        @(negedge clk); rst_n = 1;

        do_write(2'd0, 8'hFF, 8'h00, 20'h00011, "R2 all ones masked");
        do_write(2'd0, 8'h12, 8'hED, 20'h00022, "R2 prio clock");
        do_write(2'd0, 8'h80, 8'h7E, 20'hABCDE, "R3 one bit off");
        // the error pulse lasts one cycle only
        @(posedge clk); #1;
        chk("R3 pulse end", {31'd0, err_irq}, 32'd0);
        do_write(2'd0, 8'h55, 8'h55, 20'h12345, "R3 equal bytes");
        do_write(2'd1, 8'hFF, 8'h00, 20'h0F0F0, "R5 move");
        do_write(2'd2, 8'h00, 8'hFF, 20'h0F0F1, "R5 and");
        do_write(2'd3, 8'h80, 8'h7F, 20'h0F0F2, "R5 setbit");
        do_write(2'd0, 8'h69, 8'h96, 20'h00033, "R6 zero bits only");

        for (int i = 0; i < 300; i++) begin
            logic [7:0] v = 8'($urandom);
            logic [7:0] c = ($urandom % 2) ? ~v : 8'($urandom);
            do_write(2'($urandom), v, c, 20'($urandom), "R2 R3 R5 random");
        end

        do_write(2'd0, 8'h00, 8'hFF, 20'h0, "R8 prio 0");
        arb_case(1'b0, "R8");
        do_write(2'd0, 8'h10, 8'hEF, 20'h0, "R9 prio 1");
        arb_case(1'b1, "R9");

        // a single request held until ack
        @(negedge clk); wdt_req = 1;
        @(posedge clk); #1; wdt_req = 0;
        repeat (3) @(posedge clk); #1;
        chk("R10 single held", {31'd0, grant_wdt}, 32'd1);
        @(negedge clk); ack = 1;
        @(posedge clk); #1; ack = 0;
        chk("R11 single cleared", {30'd0, grant_nmi, grant_wdt}, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule